// File: doc/BRIEF.md
# Sample Record Framer with Sequence Number and CRC-8

This block sits between a sample-producing signal pipeline and a byte-serial transmitter. Each time the upstream raises a one-cycle valid strobe, the block takes a signed 16-bit sample and a one-bit detection flag. It turns them into a fixed 10-byte record. The record is handed out one byte at a time over a strobe/busy byte interface, which is the usual input of a UART transmitter.

Each record carries the following:
- a fixed sync byte and a stream identifier;
- a free-running 32-bit sequence number, so a receiver can tell when samples are missing;
- the sample and the flag;
- a trailing CRC-8, so a receiver can detect link errors.

At typical rates (a few hundred samples per second over a 1 Mbit/s link), a record finishes long before the next sample arrives. If a sample does arrive while a record is still going out, the block drops that sample and adds one to an overrun counter. The sequence number still advances, so the receiver sees the gap.

Top module: `rec_framer`

## Requirements
- R1: After reset, `tx_stb` is low, `ovr_count` is zero, and the first accepted sample carries sequence number 0.
- R2: Every record is exactly 10 bytes. Byte 0 is 0xEC and byte 1 is 0x71.
- R3: Bytes 2..5 hold the 32-bit sequence number, least significant byte first. Its value is the number of `in_valid` strobes seen since reset before this sample's strobe.
- R4: Bytes 6 and 7 hold the sample, low byte first.
- R5: Byte 8 holds the flag in bit 0, and bits 7..1 are zero.
- R6: Byte 9 is a CRC-8 over bytes 0..8, fed most significant bit first. It uses polynomial x^8+x^2+x+1 (0x07), initial value 0x00, and no final XOR.
- R7: `tx_stb` is high for one cycle per byte. It rises only when `tx_busy` was low in the previous cycle, and it is never high in two consecutive cycles.
- R8: An `in_valid` strobe that arrives while a record is in progress adds one to `ovr_count`. It produces no record and does not change the record being sent.
- R9: With `tx_busy` low, the first byte of a record is strobed in the second cycle after the `in_valid` cycle. The block is free for a new sample in the cycle after the last byte's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe marking a new sample |
| in_sample | input | 16 | Signed sample value |
| in_flag | input | 1 | Detection flag for the sample |
| tx_busy | input | 1 | Downstream transmitter is busy with a byte |
| tx_data | output | 8 | Byte presented to the transmitter |
| tx_stb | output | 1 | One-cycle strobe: `tx_data` is valid |
| ovr_count | output | 16 | Number of samples dropped because a record was in progress |

## Verification
The first byte strobe is due two clock edges after the `in_valid` edge: one edge registers the fields and the next registers the byte. The bench samples `tx_stb` at the falling edge that follows that second edge. After each strobe, later bytes wait out the modelled busy window. The bench therefore never counts cycles for them; it collects bytes as they are strobed and compares each record against a layout, sequence number and CRC that it builds itself. Overrun effects are checked only after the current record has fully drained, plus a quiet period that shows no extra record appeared.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'hEC;
  localparam logic [7:0] STREAM_ID = 8'h71;
  localparam logic [7:0] CRC_POLY  = 8'h07;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int k = 0; k < 8; k++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rf_capture.sv
module rf_capture #(
  parameter int SAMPLE_W = 16,
  parameter int SEQ_W    = 32,
  parameter int OVR_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_flag,
  input  logic                rec_done,
  output logic                active,
  output logic [SEQ_W-1:0]    seq_cap,
  output logic [SAMPLE_W-1:0] smp_cap,
  output logic                flg_cap,
  output logic [OVR_W-1:0]    ovr_count
);
  logic                active_q, active_d;
  logic [SEQ_W-1:0]    seq_q, seq_d, cap_seq_q, cap_seq_d;
  logic [SAMPLE_W-1:0] smp_q, smp_d;
  logic                flg_q, flg_d;
  logic [OVR_W-1:0]    ovr_q, ovr_d;
  logic                accept, overrun;

  always_comb begin
    accept    = in_valid & ~active_q;
    overrun   = in_valid &  active_q;
    active_d  = active_q;
    seq_d     = seq_q;
    cap_seq_d = cap_seq_q;
    smp_d     = smp_q;
    flg_d     = flg_q;
    ovr_d     = ovr_q;
    if (rec_done) active_d = 1'b0;
    if (in_valid) seq_d = seq_q + 1'b1;
    if (accept) begin
      active_d  = 1'b1;
      cap_seq_d = seq_q;
      smp_d     = in_sample;
      flg_d     = in_flag;
    end
    if (overrun) ovr_d = ovr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      seq_q     <= '0;
      cap_seq_q <= '0;
      smp_q     <= '0;
      flg_q     <= 1'b0;
      ovr_q     <= '0;
    end else begin
      active_q  <= active_d;
      seq_q     <= seq_d;
      cap_seq_q <= cap_seq_d;
      smp_q     <= smp_d;
      flg_q     <= flg_d;
      ovr_q     <= ovr_d;
    end
  end

  assign active    = active_q;
  assign seq_cap   = cap_seq_q;
  assign smp_cap   = smp_q;
  assign flg_cap   = flg_q;
  assign ovr_count = ovr_q;

  // R3: every strobe advances the sequence number, accepted or not
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> seq_q == $past(seq_q) + 1'b1);
  // R8: a strobe during a record bumps the overrun count
  a_r8_ovr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && active_q) |=> ovr_q == $past(ovr_q) + 1'b1);
  // R8: a dropped sample leaves the captured record untouched
  a_r8_keep_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && active_q) |=> ($stable(smp_q) && $stable(cap_seq_q)));
endmodule

// File: rtl/rf_crc8.sv
module rf_crc8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       first,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import rf_pkg::*;
  logic [7:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (en) crc_d = crc8_step(first ? 8'h00 : crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 8'h00;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/rf_serializer.sv
module rf_serializer #(
  parameter int SAMPLE_W = 16,
  parameter int SEQ_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic [SEQ_W-1:0]    seq_cap,
  input  logic [SAMPLE_W-1:0] smp_cap,
  input  logic                flg_cap,
  input  logic                tx_busy,
  output logic [7:0]          tx_data,
  output logic                tx_stb,
  output logic                rec_done
);
  import rf_pkg::*;
  localparam int SEQ_BYTES = SEQ_W / 8;
  localparam int SMP_BYTES = SAMPLE_W / 8;
  localparam int OFF_SEQ   = 2;
  localparam int OFF_SMP   = OFF_SEQ + SEQ_BYTES;
  localparam int OFF_FLG   = OFF_SMP + SMP_BYTES;
  localparam int OFF_CRC   = OFF_FLG + 1;
  localparam int REC_BYTES = OFF_CRC + 1;
  localparam int IDX_W     = $clog2(REC_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(OFF_CRC);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             stb_q;
  logic [7:0]       data_q, data_d;
  logic [7:0]       cur_byte, crc_val;
  logic [SEQ_W-1:0]    seq_sh;
  logic [SAMPLE_W-1:0] smp_sh;
  logic             issue;
  int               pos;

  always_comb begin
    pos      = int'(idx_q);
    seq_sh   = '0;
    smp_sh   = '0;
    cur_byte = crc_val;
    if (pos == 0)            cur_byte = SYNC_BYTE;
    else if (pos == 1)       cur_byte = STREAM_ID;
    else if (pos < OFF_SMP) begin
      seq_sh   = seq_cap >> (8 * (pos - OFF_SEQ));
      cur_byte = seq_sh[7:0];
    end else if (pos < OFF_FLG) begin
      smp_sh   = smp_cap >> (8 * (pos - OFF_SMP));
      cur_byte = smp_sh[7:0];
    end else if (pos == OFF_FLG) cur_byte = {7'b0, flg_cap};
  end

  always_comb begin
    issue    = active & ~tx_busy & ~stb_q;
    rec_done = issue & (idx_q == LAST);
    idx_d    = idx_q;
    data_d   = data_q;
    if (issue) begin
      idx_d  = (idx_q == LAST) ? '0 : idx_q + 1'b1;
      data_d = cur_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      stb_q  <= 1'b0;
      data_q <= 8'h00;
    end else begin
      idx_q  <= idx_d;
      stb_q  <= issue;
      data_q <= data_d;
    end
  end

  rf_crc8 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (issue),
    .first(idx_q == '0),
    .din  (cur_byte),
    .crc  (crc_val)
  );

  assign tx_data = data_q;
  assign tx_stb  = stb_q;

  // R7: strobe lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R7: strobe only follows a cycle with the downstream idle
  a_r7_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(!tx_busy));
  // R2: byte position stays inside the record
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
endmodule

// File: rtl/rec_framer.sv
module rec_framer #(
  parameter int SAMPLE_W = 16,
  parameter int SEQ_W    = 32,
  parameter int OVR_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_flag,
  input  logic                tx_busy,
  output logic [7:0]          tx_data,
  output logic                tx_stb,
  output logic [OVR_W-1:0]    ovr_count
);
  logic                active, rec_done, flg_cap;
  logic [SEQ_W-1:0]    seq_cap;
  logic [SAMPLE_W-1:0] smp_cap;

  rf_capture #(.SAMPLE_W(SAMPLE_W), .SEQ_W(SEQ_W), .OVR_W(OVR_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .in_flag  (in_flag),
    .rec_done (rec_done),
    .active   (active),
    .seq_cap  (seq_cap),
    .smp_cap  (smp_cap),
    .flg_cap  (flg_cap),
    .ovr_count(ovr_count)
  );

  rf_serializer #(.SAMPLE_W(SAMPLE_W), .SEQ_W(SEQ_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .seq_cap (seq_cap),
    .smp_cap (smp_cap),
    .flg_cap (flg_cap),
    .tx_busy (tx_busy),
    .tx_data (tx_data),
    .tx_stb  (tx_stb),
    .rec_done(rec_done)
  );

  // R1: nothing is strobed in the first cycle out of reset
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !tx_stb);
endmodule

// File: tb/sim_rec_framer.sv
module sim_rec_framer;
  localparam int BUSYC = 4;
  localparam int NV    = 6;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'h0000}, {1'b1, 16'h1234}, {1'b0, 16'hFFFF},
    {1'b1, 16'h8000}, {1'b0, 16'h7FFF}, {1'b1, 16'hA55A}};

  logic clk = 1'b0;
  logic rst_n, in_valid, in_flag, tx_busy;
  logic [15:0] in_sample;
  logic [7:0]  tx_data;
  logic        tx_stb;
  logic [15:0] ovr_count;

  int checks = 0, failures = 0;
  int rx_n = 0, busy_cnt = 0, stb_viol = 0, stb_prev = 0;
  logic [7:0] rx [0:255];
  bit done = 0;

  always #2 clk = ~clk;

  rec_framer u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_flag(in_flag), .tx_busy(tx_busy), .tx_data(tx_data), .tx_stb(tx_stb),
    .ovr_count(ovr_count));

  // downstream transmitter model: busy for BUSYC cycles after each strobe
  always @(posedge clk) begin
    if (tx_stb) begin
      rx[rx_n[7:0]] <= tx_data;
      rx_n     <= rx_n + 1;
      busy_cnt <= BUSYC;
      tx_busy  <= 1'b1;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
      tx_busy  <= (busy_cnt != 1);
    end
  end

  always @(negedge clk) begin
    if (rst_n && tx_stb && (tx_busy || stb_prev != 0)) stb_viol <= stb_viol + 1;
    stb_prev <= int'(tx_stb);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] b [10], input int n);
    logic [7:0] r = 8'h00;
    for (int j = 0; j < n; j++)
      for (int i = 7; i >= 0; i--) begin
        logic fb = r[7] ^ b[j][i];
        r = {r[6:0], 1'b0};
        if (fb) r = r ^ 8'h07;
      end
    return r;
  endfunction

  task automatic pulse(input logic [15:0] s, input logic f);
    @(negedge clk);
    in_sample = s; in_flag = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_bytes(input int n);
    for (int k = 0; k < 2000 && rx_n < n; k++) @(negedge clk);
  endtask

  task automatic check_rec(input int base, input logic [31:0] seq, input logic [15:0] s, input logic f);
    logic [7:0] e [10];
    e[0] = 8'hEC; e[1] = 8'h71;
    e[2] = seq[7:0]; e[3] = seq[15:8]; e[4] = seq[23:16]; e[5] = seq[31:24];
    e[6] = s[7:0]; e[7] = s[15:8]; e[8] = {7'b0, f};
    e[9] = ref_crc(e, 9);
    chk(rx_n >= base + 10, "R2 record length", rx_n, base + 10);
    chk(rx[base] == e[0] && rx[base+1] == e[1], "R2 sync/id",
        {rx[base], rx[base+1]}, {e[0], e[1]});
    chk({rx[base+5], rx[base+4], rx[base+3], rx[base+2]} == seq, "R3 sequence",
        {rx[base+5], rx[base+4], rx[base+3], rx[base+2]}, seq);
    chk({rx[base+7], rx[base+6]} == s, "R4 sample", {rx[base+7], rx[base+6]}, s);
    chk(rx[base+8] == e[8], "R5 flag byte", rx[base+8], e[8]);
    chk(rx[base+9] == e[9], "R6 crc", rx[base+9], e[9]);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; in_flag = 1'b0; tx_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_stb == 1'b0, "R1 stb after reset", tx_stb, 0);
    chk(ovr_count == 16'd0, "R1 overrun after reset", ovr_count, 0);

    // vector table: one record per entry, sequence equals entry index
    for (int v = 0; v < NV; v++) begin
      base = rx_n;
      @(negedge clk);
      in_sample = VEC[v][15:0]; in_flag = VEC[v][16]; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(tx_stb == 1'b0, "R9 no strobe one cycle after valid", tx_stb, 0);
      @(negedge clk);
      chk(tx_stb == 1'b1, "R9 first strobe two cycles after valid", tx_stb, 1);
      wait_bytes(base + 10);
      repeat (BUSYC + 2) @(negedge clk);
      check_rec(base, v, VEC[v][15:0], VEC[v][16]);
    end

    // R8: strobe during a record is dropped and counted
    base = rx_n;
    pulse(16'h0BAD, 1'b1);
    repeat (3) @(negedge clk);
    pulse(16'hDEAD, 1'b0);
    wait_bytes(base + 10);
    repeat (80) @(negedge clk);
    chk(rx_n == base + 10, "R8 dropped sample makes no record", rx_n, base + 10);
    chk(ovr_count == 16'd1, "R8 overrun count", ovr_count, 1);
    check_rec(base, NV, 16'h0BAD, 1'b1);

    // R3/R8: sequence number skips the dropped sample
    base = rx_n;
    pulse(16'h0042, 1'b0);
    wait_bytes(base + 10);
    repeat (BUSYC + 2) @(negedge clk);
    check_rec(base, NV + 2, 16'h0042, 1'b0);
    chk(ovr_count == 16'd1, "R8 overrun unchanged by clean sample", ovr_count, 1);

    chk(stb_viol == 0, "R7 strobe rules", stb_viol, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule